// File: doc/BRIEF.md
# Multi-level tagged I/O translation cache

This block is a small fully associative cache of address translations for an I/O memory management unit. Every cached mapping carries a tag made of an address-space ID, a virtual-machine ID, the input address aligned to the mapping's span, a 2-bit translation granule code and the table level at which a walker found the mapping. A table walker fills the cache through the insert port. Translation requests use the lookup port. Software-driven maintenance uses the invalidation port.

A lookup receives the requester's IDs, the input-region size field (TSZ) and the granule code. It works out the first table level that the configuration can use. It then probes that level and each deeper level down to level 3, masking the address to that level's span, and reports the first match. The result is registered one cycle after the request. The invalidation port offers four commands. Flush-all completes in a single cycle. By-ASID, by-VMID and address-range removal sweep the entries one per cycle with `busy_o` raised. A range command whose tag is exact is first tried as a one-cycle removal of that single entry.

Top module: `iotlb`

## Requirements
- R1: After reset the cache holds no valid entry, `busy_o` and `lk_done_o` are low, and both lookup counters read zero.
- R2: A lookup hits an entry only if ASID, VMID and granule code are all equal to the entry's. The address masked to the entry's span must also equal the entry's stored address. If any of these differs, the lookup misses.
- R3: Granule log2 g is 12, 14 or 16 for granule codes 1, 2 and 3, and code 0 is treated as 4 KB. The span at level L is 2^(g + (3-L)(g-3)) bytes. The first probed level is 4 - (60 - TSZ) / (g - 3), using integer division, and shallower levels are not probed. The hit reported is the matching entry at the lowest probed level. The output address is the entry's aligned output base ORed with the input address bits below the span. `lk_mask_o` equals span-1. The result appears on `lk_done_o` in the cycle after the request is accepted.
- R4: An insert writes the lowest-numbered invalid slot. If every slot is valid, the insert first removes all entries and then writes the new one. Stored input and output addresses are aligned down to the span.
- R5: Invalidation op 0 (flush-all) removes every entry within one cycle, and `busy_o` does not rise.
- R6: Op 1 (by-ASID) and op 2 (by-VMID) remove exactly the entries whose tag carries the given ID. `busy_o` stays high for NUM_ENTRIES cycles.
- R7: Op 3 (range) forms the range mask as (pages << log2 granule) - 1, where a request granule code of 0 means 4 KB. It removes an entry if either of two conditions holds. The first is that the request address ANDed with the inverse of the entry's mask equals the entry address. The second is that the entry address ANDed with the inverse of the range mask equals the request address. A given ASID or VMID (enable bit set) must also match.
- R8: An op 3 command with a nonzero level hint, a page count of 1 and an ASID given removes, in one cycle and without `busy_o`, any entry whose tag equals it exactly. The compared fields are ASID, VMID if given, address, granule code, and level equal to the hint. If no entry matches, the command performs the R7 sweep.
- R9: Every accepted lookup adds one to `hit_cnt_o` on a hit or to `miss_cnt_o` on a miss, in the same cycle as its result.
- R10: While `busy_o` is high, lookups, inserts and invalidation commands are ignored. An invalidation command presented in the same cycle as an insert takes precedence, and the insert is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_asid_i | input | IdW | Lookup address-space ID |
| lk_vmid_i | input | IdW | Lookup virtual-machine ID |
| lk_tsz_i | input | 6 | Input-region size field (input size = 64 - value) |
| lk_gcode_i | input | 2 | Lookup granule code |
| lk_addr_i | input | AddrW | Lookup input address |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_oaddr_o | output | AddrW | Translated address |
| lk_mask_o | output | AddrW | Span mask of the hit entry |
| lk_perm_o | output | PermW | Permissions of the hit entry |
| ins_valid_i | input | 1 | Insert request |
| ins_asid_i | input | IdW | Insert ASID |
| ins_vmid_i | input | IdW | Insert VMID |
| ins_iaddr_i | input | AddrW | Insert input address |
| ins_gcode_i | input | 2 | Insert granule code |
| ins_level_i | input | 2 | Insert table level |
| ins_oaddr_i | input | AddrW | Insert output address |
| ins_perm_i | input | PermW | Insert permissions |
| inv_valid_i | input | 1 | Invalidation command |
| inv_op_i | input | 2 | 0 all, 1 by ASID, 2 by VMID, 3 range |
| inv_asid_en_i | input | 1 | ASID given |
| inv_asid_i | input | IdW | Invalidation ASID |
| inv_vmid_en_i | input | 1 | VMID given |
| inv_vmid_i | input | IdW | Invalidation VMID |
| inv_addr_i | input | AddrW | Range start address |
| inv_gcode_i | input | 2 | Range granule code |
| inv_pages_i | input | PAGES_W | Range page count |
| inv_level_i | input | 2 | Level hint (0 = none) |
| busy_o | output | 1 | Sweep in progress |
| hit_cnt_o | output | CNT_W | Lookup hit count |
| miss_cnt_o | output | CNT_W | Lookup miss count |

## Verification
The bench builds the cache with NUM_ENTRIES = 4 and keeps the 48-bit address and 16-bit IDs. Four slots let a few inserts fill the cache, so the flush on a full insert can be reached. With four slots, reuse of a slot freed by an exact removal can also be reached, and the sweep length can be measured at exactly four cycles. Overlapping level-2 and level-3 entries exercise the lowest-level-first choice. TSZ values that move the first probed level past level 2 exercise the level cut-off. Range requests that lie inside a large entry and that cover a small entry exercise both directions of the range match.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  parameter int AddrW = 48;
  parameter int IdW   = 16;
  parameter int PermW = 2;

  typedef enum logic [1:0] {
    INV_ALL   = 2'd0,
    INV_ASID  = 2'd1,
    INV_VMID  = 2'd2,
    INV_RANGE = 2'd3
  } inv_op_e;

  typedef struct packed {
    logic             valid;
    logic [IdW-1:0]   asid;
    logic [IdW-1:0]   vmid;
    logic [AddrW-1:0] iaddr;
    logic [1:0]       gcode;
    logic [1:0]       level;
  } tag_t;

  typedef struct packed {
    tag_t             tag;
    logic [AddrW-1:0] oaddr;
    logic [PermW-1:0] perm;
  } entry_t;

  function automatic int gran_log2(logic [1:0] g);
    return (g == 2'd0) ? 12 : 10 + 2 * int'(g);
  endfunction

  function automatic logic [AddrW-1:0] span_mask(logic [1:0] lvl, logic [1:0] g);
    int gl;
    int s;
    gl = gran_log2(g);
    s  = gl + (3 - int'(lvl)) * (gl - 3);
    if (s >= AddrW) return '1;
    return (AddrW'(1) << s) - AddrW'(1);
  endfunction

  function automatic int start_level(logic [5:0] tsz, logic [1:0] g);
    int insz;
    int stride;
    insz   = 64 - int'(tsz);
    stride = gran_log2(g) - 3;
    return 4 - (insz - 4) / stride;
  endfunction
endpackage

// File: rtl/iotlb_lookup.sv
module iotlb_lookup
  import iotlb_pkg::*;
#(
  parameter int N = 8
) (
  input  entry_t [N-1:0]   ents_i,
  input  logic [IdW-1:0]   asid_i,
  input  logic [IdW-1:0]   vmid_i,
  input  logic [5:0]       tsz_i,
  input  logic [1:0]       gcode_i,
  input  logic [AddrW-1:0] addr_i,
  output logic             hit_o,
  output logic [AddrW-1:0] oaddr_o,
  output logic [AddrW-1:0] mask_o,
  output logic [PermW-1:0] perm_o
);
  logic [3:0][N-1:0]       match;
  logic [3:0][AddrW-1:0]   lmask;
  int                      first_lvl;

  assign first_lvl = start_level(tsz_i, gcode_i);

  for (genvar l = 0; l < 4; l++) begin : g_lvl
    assign lmask[l] = span_mask(2'(l), gcode_i);
    for (genvar e = 0; e < N; e++) begin : g_ent
      assign match[l][e] = (l >= first_lvl) && ents_i[e].tag.valid &&
                           ents_i[e].tag.asid  == asid_i &&
                           ents_i[e].tag.vmid  == vmid_i &&
                           ents_i[e].tag.gcode == gcode_i &&
                           ents_i[e].tag.level == 2'(l) &&
                           ents_i[e].tag.iaddr == (addr_i & ~lmask[l]);
    end
  end

  // shallowest level first, lowest slot within a level
  always_comb begin
    hit_o   = 1'b0;
    oaddr_o = '0;
    mask_o  = '0;
    perm_o  = '0;
    for (int l = 0; l < 4; l++) begin
      for (int e = 0; e < N; e++) begin
        if (!hit_o && match[l][e]) begin
          hit_o   = 1'b1;
          oaddr_o = ents_i[e].oaddr | (addr_i & lmask[l]);
          mask_o  = lmask[l];
          perm_o  = ents_i[e].perm;
        end
      end
    end
  end
endmodule

// File: rtl/iotlb_store.sv
module iotlb_store
  import iotlb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ins_en_i,
  input  entry_t         ins_ent_i,
  input  logic           clr_all_i,
  input  logic [N-1:0]   clr_vec_i,
  output entry_t [N-1:0] ents_o
);
  localparam int IdxW = (N > 1) ? $clog2(N) : 1;

  entry_t [N-1:0] ents_q;
  logic [N-1:0]   vld;
  logic           full;
  logic [IdxW-1:0] free_idx;
  entry_t         new_ent;
  logic [AddrW-1:0] amask;

  for (genvar e = 0; e < N; e++) begin : g_vld
    assign vld[e] = ents_q[e].tag.valid;
  end

  always_comb begin
    full     = 1'b1;
    free_idx = '0;
    for (int e = N - 1; e >= 0; e--) begin
      if (!vld[e]) begin
        full     = 1'b0;
        free_idx = IdxW'(e);
      end
    end
  end

  assign amask                 = span_mask(ins_ent_i.tag.level, ins_ent_i.tag.gcode);
  always_comb begin
    new_ent           = ins_ent_i;
    new_ent.tag.valid = 1'b1;
    new_ent.tag.iaddr = ins_ent_i.tag.iaddr & ~amask;
    new_ent.oaddr     = ins_ent_i.oaddr & ~amask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ents_q <= '0;
    end else if (clr_all_i) begin
      for (int e = 0; e < N; e++) ents_q[e].tag.valid <= 1'b0;
    end else begin
      for (int e = 0; e < N; e++) begin
        if (clr_vec_i[e]) ents_q[e].tag.valid <= 1'b0;
      end
      if (ins_en_i) begin
        if (full) begin
          for (int e = 1; e < N; e++) ents_q[e].tag.valid <= 1'b0;
          ents_q[0] <= new_ent;
        end else begin
          ents_q[free_idx] <= new_ent;
        end
      end
    end
  end

  assign ents_o = ents_q;

  p_flush_on_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_en_i && full && !clr_all_i) |=> ($countones(vld) == 1));

  p_insert_grows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_en_i && !full && !clr_all_i && clr_vec_i == '0)
      |=> ($countones(vld) == $past($countones(vld)) + 1));

  p_clear_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (vld == '0));
endmodule

// File: rtl/iotlb_inv.sv
module iotlb_inv
  import iotlb_pkg::*;
#(
  parameter int N       = 8,
  parameter int PAGES_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_i,
  input  inv_op_e            op_i,
  input  logic               asid_en_i,
  input  logic [IdW-1:0]     asid_i,
  input  logic               vmid_en_i,
  input  logic [IdW-1:0]     vmid_i,
  input  logic [AddrW-1:0]   addr_i,
  input  logic [1:0]         gcode_i,
  input  logic [PAGES_W-1:0] pages_i,
  input  logic [1:0]         ttl_i,
  input  tag_t [N-1:0]       tags_i,
  output logic               busy_o,
  output logic               clr_all_o,
  output logic [N-1:0]       clr_vec_o
);
  localparam int IdxW = (N > 1) ? $clog2(N) : 1;

  logic             busy_q;
  logic [IdxW-1:0]  idx_q;
  inv_op_e          op_q;
  logic             asid_en_q, vmid_en_q;
  logic [IdW-1:0]   asid_q, vmid_q;
  logic [AddrW-1:0] addr_q, rmask_q, rmask_d;
  logic [N-1:0]     exact_vec;
  logic             exact_try, start;
  tag_t             cur;
  logic             cur_hit;

  assign exact_try = cmd_i && op_i == INV_RANGE && ttl_i != 2'd0 &&
                     pages_i == PAGES_W'(1) && asid_en_i;

  for (genvar e = 0; e < N; e++) begin : g_exact
    assign exact_vec[e] = tags_i[e].valid && tags_i[e].asid == asid_i &&
                          (!vmid_en_i || tags_i[e].vmid == vmid_i) &&
                          tags_i[e].iaddr == addr_i && tags_i[e].gcode == gcode_i &&
                          tags_i[e].level == ttl_i;
  end

  assign rmask_d = (AddrW'(pages_i) << gran_log2(gcode_i)) - AddrW'(1);
  assign start   = cmd_i && op_i != INV_ALL && !(exact_try && |exact_vec);
  assign cur     = tags_i[idx_q];

  always_comb begin
    case (op_q)
      INV_ASID: cur_hit = cur.asid == asid_q;
      INV_VMID: cur_hit = cur.vmid == vmid_q;
      INV_RANGE: cur_hit = (!asid_en_q || cur.asid == asid_q) &&
                           (!vmid_en_q || cur.vmid == vmid_q) &&
                           (((addr_q & ~span_mask(cur.level, cur.gcode)) == cur.iaddr) ||
                            ((cur.iaddr & ~rmask_q) == addr_q));
      default: cur_hit = 1'b0;
    endcase
  end

  always_comb begin
    clr_vec_o = '0;
    if (busy_q) clr_vec_o[idx_q] = cur.valid && cur_hit;
    else if (exact_try) clr_vec_o = exact_vec;
  end

  assign clr_all_o = cmd_i && op_i == INV_ALL;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      op_q      <= INV_ALL;
      asid_en_q <= 1'b0;
      vmid_en_q <= 1'b0;
      asid_q    <= '0;
      vmid_q    <= '0;
      addr_q    <= '0;
      rmask_q   <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      idx_q     <= '0;
      op_q      <= op_i;
      asid_en_q <= asid_en_i;
      vmid_en_q <= vmid_en_i;
      asid_q    <= asid_i;
      vmid_q    <= vmid_i;
      addr_q    <= addr_i;
      rmask_q   <= rmask_d;
    end else if (busy_q) begin
      if (idx_q == IdxW'(N - 1)) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  // independent run-length counter for the sweep window
  logic [IdxW:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (!busy_q) run_q <= '0;
    else run_q <= run_q + 1'b1;
  end

  p_sweep_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (run_q == (IdxW+1)'(N)));

  p_exact_no_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && exact_try && |exact_vec) |=> !busy_q);

  p_no_cmd_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !cmd_i);
endmodule

// File: rtl/iotlb.sv
module iotlb
  import iotlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PAGES_W     = 8,
  parameter int CNT_W       = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [IdW-1:0]     lk_asid_i,
  input  logic [IdW-1:0]     lk_vmid_i,
  input  logic [5:0]         lk_tsz_i,
  input  logic [1:0]         lk_gcode_i,
  input  logic [AddrW-1:0]   lk_addr_i,
  output logic               lk_done_o,
  output logic               lk_hit_o,
  output logic [AddrW-1:0]   lk_oaddr_o,
  output logic [AddrW-1:0]   lk_mask_o,
  output logic [PermW-1:0]   lk_perm_o,
  input  logic               ins_valid_i,
  input  logic [IdW-1:0]     ins_asid_i,
  input  logic [IdW-1:0]     ins_vmid_i,
  input  logic [AddrW-1:0]   ins_iaddr_i,
  input  logic [1:0]         ins_gcode_i,
  input  logic [1:0]         ins_level_i,
  input  logic [AddrW-1:0]   ins_oaddr_i,
  input  logic [PermW-1:0]   ins_perm_i,
  input  logic               inv_valid_i,
  input  logic [1:0]         inv_op_i,
  input  logic               inv_asid_en_i,
  input  logic [IdW-1:0]     inv_asid_i,
  input  logic               inv_vmid_en_i,
  input  logic [IdW-1:0]     inv_vmid_i,
  input  logic [AddrW-1:0]   inv_addr_i,
  input  logic [1:0]         inv_gcode_i,
  input  logic [PAGES_W-1:0] inv_pages_i,
  input  logic [1:0]         inv_level_i,
  output logic               busy_o,
  output logic [CNT_W-1:0]   hit_cnt_o,
  output logic [CNT_W-1:0]   miss_cnt_o
);
  localparam int N = NUM_ENTRIES;

  entry_t [N-1:0] ents;
  tag_t   [N-1:0] tags;
  entry_t         ins_ent;
  logic           busy, clr_all, ins_en, inv_cmd, lk_acc;
  logic [N-1:0]   clr_vec;
  logic           p_hit;
  logic [AddrW-1:0] p_oaddr, p_mask;
  logic [PermW-1:0] p_perm;

  for (genvar e = 0; e < N; e++) begin : g_tags
    assign tags[e] = ents[e].tag;
  end

  assign inv_cmd = inv_valid_i && !busy;
  assign ins_en  = ins_valid_i && !busy && !inv_valid_i;
  assign lk_acc  = lk_valid_i && !busy;

  always_comb begin
    ins_ent           = '0;
    ins_ent.tag.asid  = ins_asid_i;
    ins_ent.tag.vmid  = ins_vmid_i;
    ins_ent.tag.iaddr = ins_iaddr_i;
    ins_ent.tag.gcode = ins_gcode_i;
    ins_ent.tag.level = ins_level_i;
    ins_ent.oaddr     = ins_oaddr_i;
    ins_ent.perm      = ins_perm_i;
  end

  iotlb_store #(.N(N)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ins_en_i  (ins_en),
    .ins_ent_i (ins_ent),
    .clr_all_i (clr_all),
    .clr_vec_i (clr_vec),
    .ents_o    (ents)
  );

  iotlb_inv #(.N(N), .PAGES_W(PAGES_W)) u_inv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (inv_cmd),
    .op_i      (inv_op_e'(inv_op_i)),
    .asid_en_i (inv_asid_en_i),
    .asid_i    (inv_asid_i),
    .vmid_en_i (inv_vmid_en_i),
    .vmid_i    (inv_vmid_i),
    .addr_i    (inv_addr_i),
    .gcode_i   (inv_gcode_i),
    .pages_i   (inv_pages_i),
    .ttl_i     (inv_level_i),
    .tags_i    (tags),
    .busy_o    (busy),
    .clr_all_o (clr_all),
    .clr_vec_o (clr_vec)
  );

  iotlb_lookup #(.N(N)) u_lookup (
    .ents_i  (ents),
    .asid_i  (lk_asid_i),
    .vmid_i  (lk_vmid_i),
    .tsz_i   (lk_tsz_i),
    .gcode_i (lk_gcode_i),
    .addr_i  (lk_addr_i),
    .hit_o   (p_hit),
    .oaddr_o (p_oaddr),
    .mask_o  (p_mask),
    .perm_o  (p_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o  <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_oaddr_o <= '0;
      lk_mask_o  <= '0;
      lk_perm_o  <= '0;
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      lk_done_o <= lk_acc;
      if (lk_acc) begin
        lk_hit_o   <= p_hit;
        lk_oaddr_o <= p_hit ? p_oaddr : '0;
        lk_mask_o  <= p_hit ? p_mask : '0;
        lk_perm_o  <= p_hit ? p_perm : '0;
        if (p_hit) hit_cnt_o <= hit_cnt_o + 1'b1;
        else miss_cnt_o <= miss_cnt_o + 1'b1;
      end
    end
  end

  assign busy_o = busy;

  p_busy_stalls_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !lk_done_o);

  p_count_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_done_o |-> (CNT_W'(hit_cnt_o + miss_cnt_o) ==
                   CNT_W'($past(hit_cnt_o) + $past(miss_cnt_o) + 1'b1)));

  p_mask_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && lk_hit_o) |-> ((lk_mask_o & (lk_mask_o + 1'b1)) == '0));
endmodule

// File: tb/sim_iotlb.sv
`timescale 1ns/1ps
module sim_iotlb;
  import iotlb_pkg::*;
  localparam int NE = 4;
  localparam int PW = 8;
  localparam int CW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic lk_valid = 0; logic [IdW-1:0] lk_asid = 0, lk_vmid = 0;
  logic [5:0] lk_tsz = 0; logic [1:0] lk_gcode = 0; logic [AddrW-1:0] lk_addr = 0;
  logic lk_done, lk_hit; logic [AddrW-1:0] lk_oaddr, lk_mask; logic [PermW-1:0] lk_perm;
  logic ins_valid = 0; logic [IdW-1:0] ins_asid = 0, ins_vmid = 0;
  logic [AddrW-1:0] ins_iaddr = 0, ins_oaddr = 0; logic [1:0] ins_gcode = 0, ins_level = 0;
  logic [PermW-1:0] ins_perm = 0;
  logic inv_valid = 0; logic [1:0] inv_op = 0; logic inv_asid_en = 0, inv_vmid_en = 0;
  logic [IdW-1:0] inv_asid = 0, inv_vmid = 0; logic [AddrW-1:0] inv_addr = 0;
  logic [1:0] inv_gcode = 0, inv_level = 0; logic [PW-1:0] inv_pages = 0;
  logic busy; logic [CW-1:0] hit_cnt, miss_cnt;

  iotlb #(.NUM_ENTRIES(NE), .PAGES_W(PW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_asid_i(lk_asid), .lk_vmid_i(lk_vmid), .lk_tsz_i(lk_tsz),
    .lk_gcode_i(lk_gcode), .lk_addr_i(lk_addr),
    .lk_done_o(lk_done), .lk_hit_o(lk_hit), .lk_oaddr_o(lk_oaddr), .lk_mask_o(lk_mask),
    .lk_perm_o(lk_perm),
    .ins_valid_i(ins_valid), .ins_asid_i(ins_asid), .ins_vmid_i(ins_vmid),
    .ins_iaddr_i(ins_iaddr), .ins_gcode_i(ins_gcode), .ins_level_i(ins_level),
    .ins_oaddr_i(ins_oaddr), .ins_perm_i(ins_perm),
    .inv_valid_i(inv_valid), .inv_op_i(inv_op), .inv_asid_en_i(inv_asid_en),
    .inv_asid_i(inv_asid), .inv_vmid_en_i(inv_vmid_en), .inv_vmid_i(inv_vmid),
    .inv_addr_i(inv_addr), .inv_gcode_i(inv_gcode), .inv_pages_i(inv_pages),
    .inv_level_i(inv_level),
    .busy_o(busy), .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  int n_chk = 0, n_err = 0, exp_hits = 0, exp_miss = 0, busy_cnt = 0;
  localparam logic [AddrW-1:0] M4K = 48'hFFF, M2M = 48'h1F_FFFF;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ins(input logic [IdW-1:0] a, v, input logic [AddrW-1:0] ia,
                     input logic [1:0] g, l, input logic [AddrW-1:0] oa, input logic [1:0] p);
    @(negedge clk);
    ins_valid = 1; ins_asid = a; ins_vmid = v; ins_iaddr = ia; ins_gcode = g;
    ins_level = l; ins_oaddr = oa; ins_perm = p;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic inv(input logic [1:0] op, input logic ae, input logic [IdW-1:0] a,
                     input logic ve, input logic [IdW-1:0] v, input logic [AddrW-1:0] ad,
                     input logic [1:0] g, input logic [PW-1:0] pg, input logic [1:0] lv);
    @(negedge clk);
    inv_valid = 1; inv_op = op; inv_asid_en = ae; inv_asid = a; inv_vmid_en = ve;
    inv_vmid = v; inv_addr = ad; inv_gcode = g; inv_pages = pg; inv_level = lv;
    @(negedge clk);
    inv_valid = 0;
    busy_cnt = 0;
    while (busy) begin busy_cnt++; @(negedge clk); end
  endtask

  task automatic flush_all();
    inv(2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(string req, input logic [IdW-1:0] a, v, input logic [5:0] tsz,
                      input logic [1:0] g, input logic [AddrW-1:0] ad, input bit eh,
                      input logic [AddrW-1:0] eo = 0, input logic [AddrW-1:0] em = 0,
                      input logic [1:0] ep = 0);
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_vmid = v; lk_tsz = tsz; lk_gcode = g; lk_addr = ad;
    @(negedge clk);
    lk_valid = 0;
    chk({req, " done"}, lk_done, 1);
    chk({req, " hit"}, lk_hit, eh);
    if (eh) begin
      exp_hits++;
      chk({req, " oaddr"}, lk_oaddr, eo);
      chk({req, " mask"}, lk_mask, em);
      chk({req, " perm"}, lk_perm, ep);
    end else exp_miss++;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", lk_done, 0);
    chk("R1 hits", hit_cnt, 0);
    chk("R1 misses", miss_cnt, 0);
    look("R1 empty", 1, 2, 16, 1, 48'h1234_5678, 0);
  endtask

  task automatic t_tags();
    flush_all();
    ins(1, 2, 48'h1234_5ABC, 1, 3, 48'hABC_0DEF, 2'd3);
    look("R3 basic", 1, 2, 16, 1, 48'h1234_5678, 1, 48'hABC_0678, M4K, 2'd3);
    look("R2 asid", 9, 2, 16, 1, 48'h1234_5678, 0);
    look("R2 vmid", 1, 9, 16, 1, 48'h1234_5678, 0);
    look("R2 gcode", 1, 2, 16, 2, 48'h1234_5678, 0);
    look("R2 page", 1, 2, 16, 1, 48'h1234_6678, 0);
  endtask

  task automatic t_levels();
    flush_all();
    ins(1, 2, 48'h4000_0000, 1, 2, 48'h8000_0000, 2'd1);
    ins(1, 2, 48'h4000_0000, 1, 3, 48'h0, 2'd2);
    look("R3 L2 first", 1, 2, 16, 1, 48'h4000_0010, 1, 48'h8000_0010, M2M, 2'd1);
    look("R3 start L2", 1, 2, 39, 1, 48'h4012_3456, 1, 48'h8012_3456, M2M, 2'd1);
    look("R3 start L3", 1, 2, 48, 1, 48'h4000_0010, 1, 48'h10, M4K, 2'd2);
    look("R3 start L3 miss", 1, 2, 48, 1, 48'h4012_3456, 0);
  endtask

  task automatic t_id_sweeps();
    flush_all();
    ins(1, 2, 48'h1000, 1, 3, 48'h1000, 1);
    ins(1, 3, 48'h2000, 1, 3, 48'h2000, 1);
    ins(7, 2, 48'h3000, 1, 3, 48'h3000, 1);
    ins(7, 9, 48'h4000, 1, 3, 48'h4000, 1);
    inv(2'd1, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 asid busy len", busy_cnt, NE);
    look("R6 asid gone a", 1, 2, 16, 1, 48'h1000, 0);
    look("R6 asid gone b", 1, 3, 16, 1, 48'h2000, 0);
    look("R6 asid kept", 7, 2, 16, 1, 48'h3000, 1, 48'h3000, M4K, 1);
    inv(2'd2, 0, 0, 1, 9, 0, 0, 0, 0);
    chk("R6 vmid busy len", busy_cnt, NE);
    look("R6 vmid gone", 7, 9, 16, 1, 48'h4000, 0);
    look("R6 vmid kept", 7, 2, 16, 1, 48'h3000, 1, 48'h3000, M4K, 1);
  endtask

  task automatic t_fill();
    flush_all();
    for (int k = 0; k < NE; k++) ins(4, 4, 48'h1000_0000 + k * 48'h1000, 1, 3, 48'h5000 + k * 48'h1000, 0);
    look("R4 full no flush", 4, 4, 16, 1, 48'h1000_0000, 1, 48'h5000, M4K, 0);
    ins(4, 4, 48'h2000_0000, 1, 3, 48'h7700_0000, 3);
    look("R4 flushed", 4, 4, 16, 1, 48'h1000_0000, 0);
    look("R4 newest", 4, 4, 16, 1, 48'h2000_0123, 1, 48'h7700_0123, M4K, 3);
    for (int k = 1; k < NE; k++) ins(4, 4, 48'h1000_0000 + k * 48'h1000, 1, 3, 48'h5000, 0);
    inv(2'd3, 1, 4, 0, 0, 48'h1000_1000, 1, 1, 3);
    ins(4, 4, 48'h3000_0000, 1, 3, 48'h9000, 1);
    look("R4 free reused", 4, 4, 16, 1, 48'h2000_0000, 1, 48'h7700_0000, M4K, 3);
    look("R4 reused new", 4, 4, 16, 1, 48'h3000_0000, 1, 48'h9000, M4K, 1);
  endtask

  task automatic t_flush();
    ins(5, 5, 48'h6000, 1, 3, 48'h6000, 0);
    flush_all();
    chk("R5 no busy", busy_cnt, 0);
    look("R5 gone", 5, 5, 16, 1, 48'h6000, 0);
    look("R5 gone old", 4, 4, 16, 1, 48'h3000_0000, 0);
  endtask

  task automatic t_range();
    flush_all();
    ins(1, 2, 48'h4000_0000, 1, 2, 48'h8000_0000, 0);
    ins(1, 2, 48'h5000_0000, 1, 3, 48'h5000_0000, 0);
    inv(2'd3, 0, 0, 0, 0, 48'h4010_0000, 1, 1, 0);
    chk("R7 sweep len", busy_cnt, NE);
    look("R7 req in entry", 1, 2, 16, 1, 48'h4000_0000, 0);
    look("R7 other kept", 1, 2, 16, 1, 48'h5000_0000, 1, 48'h5000_0000, M4K, 0);
    flush_all();
    ins(1, 2, 48'h6000_3000, 1, 3, 48'h1000, 0);
    ins(1, 2, 48'h6001_0000, 1, 3, 48'h2000, 0);
    ins(3, 2, 48'h7000_0000, 1, 3, 48'h3000, 0);
    inv(2'd3, 0, 0, 0, 0, 48'h6000_0000, 0, 16, 0);
    look("R7 entry in req", 1, 2, 16, 1, 48'h6000_3000, 0);
    look("R7 past range", 1, 2, 16, 1, 48'h6001_0000, 1, 48'h2000, M4K, 0);
    inv(2'd3, 1, 4, 0, 0, 48'h7000_0000, 1, 1, 0);
    look("R7 asid filter", 3, 2, 16, 1, 48'h7000_0000, 1, 48'h3000, M4K, 0);
  endtask

  task automatic t_exact();
    flush_all();
    ins(5, 2, 48'h3000_0000, 1, 3, 48'h1000, 0);
    ins(5, 2, 48'h2000_0000, 1, 2, 48'h0, 0);
    inv(2'd3, 1, 5, 1, 2, 48'h3000_0000, 1, 1, 3);
    chk("R8 exact no busy", busy_cnt, 0);
    look("R8 exact gone", 5, 2, 16, 1, 48'h3000_0000, 0);
    inv(2'd3, 1, 5, 0, 0, 48'h2000_1000, 1, 1, 3);
    chk("R8 fallback sweep", busy_cnt, NE);
    look("R8 fallback gone", 5, 2, 16, 1, 48'h2000_0000, 0);
  endtask

  task automatic t_busy();
    flush_all();
    @(negedge clk);
    inv_valid = 1; inv_op = 2'd1; inv_asid_en = 1; inv_asid = 99;
    @(negedge clk);
    inv_valid = 0;
    chk("R10 busy up", busy, 1);
    lk_valid = 1; lk_asid = 8; lk_vmid = 8; lk_tsz = 16; lk_gcode = 1; lk_addr = 48'h8000;
    ins_valid = 1; ins_asid = 8; ins_vmid = 8; ins_iaddr = 48'h8000; ins_gcode = 1;
    ins_level = 3; ins_oaddr = 48'h8000; ins_perm = 1;
    @(negedge clk);
    lk_valid = 0; ins_valid = 0;
    chk("R10 lookup ignored", lk_done, 0);
    while (busy) @(negedge clk);
    look("R10 insert ignored", 8, 8, 16, 1, 48'h8000, 0);
    @(negedge clk);
    inv_valid = 1; inv_op = 2'd0;
    ins_valid = 1;
    @(negedge clk);
    inv_valid = 0; ins_valid = 0;
    look("R10 inv beats insert", 8, 8, 16, 1, 48'h8000, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_tags();
    t_levels();
    t_id_sweeps();
    t_fill();
    t_flush();
    t_range();
    t_exact();
    t_busy();
    chk("R9 hit count", hit_cnt, exp_hits);
    chk("R9 miss count", miss_cnt, exp_miss);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule